// File: doc/BRIEF.md
# Dual-Mode Sigma-Delta Decimation Filter

This block turns the multi-bit code stream of an oversampling sigma-delta modulator into PCM samples at a reduced rate. Each incoming code is qualified by a strobe at the modulator rate. The code passes through a cascade of integrators running at the input rate, a decimator, and a cascade of unit-delay combs running at the decimated rate. A boxcar averaging stage then sums a fixed number of comb outputs and emits one rounded output word per group.

There are two configurations. The low-order mode pairs a third-order CIC with rate 16 and an averager of length 4, which gives an overall ratio of 64 and a 16-bit result. It suits a standalone second-order modulator. The high-order mode pairs a fourth-order CIC with rate 5 and an averager of length 5, which gives an overall ratio of 25 and a 14-bit result, sign-extended onto the output port. It suits a cascaded modulator whose combined output has higher-order shaping.

The mode input is static. It is sampled only during a clearing cycle: either the synchronous clear input, or the first clock edge after the asynchronous reset is released. A clearing cycle also empties every integrator, comb delay, phase counter and averager.

Top module: `sdm_decim`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R2: In the low-order mode (`mode_sel` = 0), the output is formed as follows.
  - Let x_k be the k-th sample accepted since the last clearing cycle, counting from k = 1.
  - Let h be the three-fold self-convolution of a length-16 run of ones.
  - The CIC output m is c_m = sum over j of h[j]·x_(16m−j).
  - Output group g (g ≥ 0) sums c_m for m = 3+4g+1 … 3+4g+4.
  - `out_data` = floor((sum + 2) / 4), as a 16-bit two's-complement word.
- R3: In the high-order mode (`mode_sel` = 1), the output is formed the same way with these changes.
  - h is the four-fold self-convolution of a length-5 run of ones, and c_m = sum over j of h[j]·x_(5m−j).
  - Group g sums c_m for m = 4+5g+1 … 4+5g+5.
  - `out_data` = floor((sum + 2) / 4). The value fits in 14 bits and is sign-extended to 16, so bits 15:13 are equal.
- R4: `out_valid` is a single-cycle pulse. It is high in the cycle after the first rising edge that follows the edge accepting the sample that completes a group. After the first pulse, pulses recur every 64 (mode 0) or 25 (mode 1) accepted samples.
- R5: The first pulse after a clearing cycle completes with accepted sample 112 in mode 0, or sample 45 in mode 1. The first 3 or 4 CIC outputs are discarded while the comb delays fill.
- R6: A cycle with `in_valid` = 0 accepts no sample, whatever `in_code` holds, and produces no pulse of its own.
- R7: `mode_sel` is sampled only in a clearing cycle. Changes at any other time have no effect on the output.
- R8: A clearing cycle accepts no sample, drives `out_valid` and `out_data` to 0 after its edge, and restarts the warm-up of R5. A clearing cycle is either `srst` = 1 at a rising edge, or the first rising edge after `rst_n` is released.
- R9: `out_data` holds its value in every cycle in which `out_valid` is 0, except after a clearing cycle.
- R10: The arithmetic does not overflow at full scale:
  - constant −8 input gives −32768 in mode 0 and −6250 in mode 1;
  - constant +7 input gives 28672 in mode 0 and 5469 in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous clear; samples `mode_sel` |
| mode_sel | input | 1 | 0: order 3, ratio 64, 16-bit; 1: order 4, ratio 25, 14-bit |
| in_valid | input | 1 | Qualifies `in_code` for one modulator sample |
| in_code | input | 4 | Signed modulator code |
| out_valid | output | 1 | One-cycle pulse marking a new output word |
| out_data | output | 16 | Signed PCM result |

## Verification
The bench builds the block with its default parameters: a 4-bit input, a 16-bit common register width, ratios 16×4 and 5×5, and orders 3 and 4. With these values both modes and their warm-up lengths are reached within a few hundred samples. Full-scale constant input drives the low-order mode exactly to −32768, where the shared integrator width has no margin left. A mode change is attempted both with and without a clearing cycle, so the sampling of `mode_sel` is exercised in both cases.

// File: rtl/sdm_decim_pkg.sv
package sdm_decim_pkg;

  // The two filter configurations.
  typedef enum logic {
    MODE_SLOW = 1'b0,  // order 3, rate 16, averager 4
    MODE_FAST = 1'b1   // order 4, rate 5,  averager 5
  } dec_mode_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdm_decim_integ.sv
// Integrator cascade: every stage adds in the same cycle, and the selected
// stage's next value is handed to the decimator.
module sdm_decim_integ #(
  parameter int STAGES = 4,
  parameter int W      = 16,
  parameter int IW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [W-1:0]  din,
  input  logic [IW-1:0] tap_idx,
  output logic [W-1:0]  tap_next
);

  logic [W-1:0] nxt_arr [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    logic [W-1:0] q;
    logic [W-1:0] feed;
    logic [W-1:0] nxt;

    if (k == 0) begin : g_head
      assign feed = din;
    end else begin : g_tail
      assign feed = g_st[k-1].nxt;
    end

    assign nxt        = q + feed;
    assign nxt_arr[k] = nxt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (en)  q <= nxt;
    end
  end

  assign tap_next = nxt_arr[tap_idx];

endmodule

// File: rtl/sdm_decim_comb.sv
// Unit-delay comb cascade at the decimated rate; inactive stages pass through.
module sdm_decim_comb #(
  parameter int STAGES = 4,
  parameter int W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [STAGES-1:0] active,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      dout
);

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    logic [W-1:0] dly;
    logic [W-1:0] feed;
    logic [W-1:0] res;

    if (k == 0) begin : g_head
      assign feed = din;
    end else begin : g_tail
      assign feed = g_st[k-1].res;
    end

    assign res = active[k] ? (feed - dly) : feed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dly <= '0;
      else if (clr) dly <= '0;
      else if (en)  dly <= feed;
    end
  end

  assign dout = g_st[STAGES-1].res;

endmodule

// File: rtl/sdm_decim_avg.sv
// Warm-up skip, boxcar sum, rounding and output register.
module sdm_decim_avg
  import sdm_decim_pkg::*;
#(
  parameter int CW     = 16,
  parameter int AW     = 19,
  parameter int OUT_W  = 16,
  parameter int OUT_W0 = 16,
  parameter int OUT_W1 = 14,
  parameter int SH0    = 2,
  parameter int SH1    = 2,
  parameter int N0     = 3,
  parameter int N1     = 4,
  parameter int L0     = 4,
  parameter int L1     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  dec_mode_e        mode,
  input  logic [CW-1:0]    y,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  localparam int SKW = $clog2(imax(N0, N1) + 1);
  localparam int CNW = imax(1, $clog2(imax(L0, L1)));
  localparam logic signed [AW-1:0] HALF0 = AW'(1) <<< (SH0 - 1);
  localparam logic signed [AW-1:0] HALF1 = AW'(1) <<< (SH1 - 1);

  logic [SKW-1:0]          skip_q, skip_d, warm;
  logic [CNW-1:0]          cnt_q, cnt_d, last;
  logic signed [AW-1:0]    acc_q, acc_d, acc_sum, rnd0, rnd1;
  logic signed [OUT_W0-1:0] t0;
  logic signed [OUT_W1-1:0] t1;
  logic [OUT_W-1:0]        data_d;
  logic                    valid_d;

  assign warm    = (mode == MODE_FAST) ? SKW'(N1) : SKW'(N0);
  assign last    = (mode == MODE_FAST) ? CNW'(L1 - 1) : CNW'(L0 - 1);
  assign acc_sum = acc_q + AW'($signed(y));
  assign rnd0    = (acc_sum + HALF0) >>> SH0;
  assign rnd1    = (acc_sum + HALF1) >>> SH1;
  assign t0      = rnd0[OUT_W0-1:0];
  assign t1      = rnd1[OUT_W1-1:0];

  always_comb begin
    skip_d  = skip_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    data_d  = out_data;
    valid_d = 1'b0;
    if (en) begin
      if (skip_q != warm) begin
        skip_d = skip_q + 1'b1;
      end else if (cnt_q == last) begin
        acc_d   = '0;
        cnt_d   = '0;
        valid_d = 1'b1;
        data_d  = (mode == MODE_FAST) ? OUT_W'(t1) : OUT_W'(t0);
      end else begin
        acc_d = acc_sum;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0; cnt_q <= '0; acc_q <= '0; out_data <= '0; out_valid <= 1'b0;
    end else if (clr) begin
      skip_q <= '0; cnt_q <= '0; acc_q <= '0; out_data <= '0; out_valid <= 1'b0;
    end else begin
      skip_q <= skip_d; cnt_q <= cnt_d; acc_q <= acc_d;
      out_data <= data_d; out_valid <= valid_d;
    end
  end

endmodule

// File: rtl/sdm_decim.sv
module sdm_decim
  import sdm_decim_pkg::*;
#(
  parameter int IN_W   = 4,
  parameter int N0     = 3,
  parameter int R0     = 16,
  parameter int L0     = 4,
  parameter int OUT_W0 = 16,
  parameter int SH0    = 2,
  parameter int N1     = 4,
  parameter int R1     = 5,
  parameter int L1     = 5,
  parameter int OUT_W1 = 14,
  parameter int SH1    = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             srst,
  input  logic                             mode_sel,
  input  logic                             in_valid,
  input  logic [IN_W-1:0]                  in_code,
  output logic                             out_valid,
  output logic [imax(OUT_W0, OUT_W1)-1:0]  out_data
);

  localparam int NMAX  = imax(N0, N1);
  localparam int GROW  = imax(N0 * $clog2(R0), N1 * $clog2(R1));
  localparam int CW    = IN_W + GROW;
  localparam int AW    = CW + $clog2(imax(L0, L1));
  localparam int OUT_W = imax(OUT_W0, OUT_W1);
  localparam int PW    = imax(1, $clog2(imax(R0, R1)));
  localparam int IW    = imax(1, $clog2(NMAX));

  dec_mode_e       mode_q, mode_d;
  logic            cfg_loaded_q;
  logic            clr_int;
  logic            accept;
  logic [PW-1:0]   phase_q, phase_d, phase_last;
  logic [CW-1:0]   dec_q, dec_d, din_ext, int_tap, comb_out;
  logic            dec_stb_q, dec_stb_d;
  logic [IW-1:0]   tap_idx;
  logic [NMAX-1:0] comb_active;

  assign clr_int    = srst | ~cfg_loaded_q;
  assign accept     = in_valid & ~clr_int;
  assign din_ext    = CW'($signed(in_code));
  assign phase_last = (mode_q == MODE_FAST) ? PW'(R1 - 1) : PW'(R0 - 1);
  assign tap_idx    = (mode_q == MODE_FAST) ? IW'(N1 - 1) : IW'(N0 - 1);

  for (genvar k = 0; k < NMAX; k++) begin : g_act
    assign comb_active[k] = (mode_q == MODE_FAST) ? (k < N1) : (k < N0);
  end

  always_comb begin
    mode_d    = mode_q;
    phase_d   = phase_q;
    dec_d     = dec_q;
    dec_stb_d = 1'b0;
    if (clr_int) begin
      mode_d  = dec_mode_e'(mode_sel);
      phase_d = '0;
      dec_d   = '0;
    end else if (in_valid) begin
      if (phase_q == phase_last) begin
        phase_d   = '0;
        dec_d     = int_tap;
        dec_stb_d = 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_loaded_q <= 1'b0;
      mode_q       <= MODE_SLOW;
      phase_q      <= '0;
      dec_q        <= '0;
      dec_stb_q    <= 1'b0;
    end else begin
      cfg_loaded_q <= 1'b1;
      mode_q       <= mode_d;
      phase_q      <= phase_d;
      dec_q        <= dec_d;
      dec_stb_q    <= dec_stb_d;
    end
  end

  sdm_decim_integ #(.STAGES(NMAX), .W(CW), .IW(IW)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr_int), .en(accept),
    .din(din_ext), .tap_idx(tap_idx), .tap_next(int_tap)
  );

  sdm_decim_comb #(.STAGES(NMAX), .W(CW)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr_int), .en(dec_stb_q),
    .active(comb_active), .din(dec_q), .dout(comb_out)
  );

  sdm_decim_avg #(
    .CW(CW), .AW(AW), .OUT_W(OUT_W), .OUT_W0(OUT_W0), .OUT_W1(OUT_W1),
    .SH0(SH0), .SH1(SH1), .N0(N0), .N1(N1), .L0(L0), .L1(L1)
  ) u_avg (
    .clk(clk), .rst_n(rst_n), .clr(clr_int), .en(dec_stb_q), .mode(mode_q),
    .y(comb_out), .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/sdm_decim_chk.sv
module sdm_decim_chk #(
  parameter int OUT_W  = 16,
  parameter int OUT_W1 = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             mode_fast,
  input logic             clr_int
);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_pulse_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !$past(clr_int)) |-> $stable(out_data));

  p_narrow_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_fast) |->
      ((&out_data[OUT_W-1:OUT_W1-1]) || !(|out_data[OUT_W-1:OUT_W1-1])));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_int |=> $stable(mode_fast));

  p_clear_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_int |=> (!out_valid && out_data == '0));

  always_comb begin
    if (!rst_n) begin
      a_reset_out_r1: assert (!out_valid && out_data == '0);
    end
  end

endmodule

bind sdm_decim sdm_decim_chk #(.OUT_W(OUT_W), .OUT_W1(OUT_W1)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .mode_fast(mode_q), .clr_int(clr_int)
);

// File: tb/sim_sdm_decim.sv
module sim_sdm_decim;

  localparam int IN_W  = 4;
  localparam int OUT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n, srst, mode_sel, in_valid;
  logic [IN_W-1:0]  in_code;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  always #5 clk = ~clk;

  sdm_decim u0 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int xs[$];
  int n_acc, prev_n, cur_mode, last_out, pulses;
  bit prev_acc;
  logic [OUT_W-1:0] held;
  int h[64];
  int hlen;

  function automatic int ord(int m);  return m ? 4 : 3;  endfunction
  function automatic int rate(int m); return m ? 5 : 16; endfunction
  function automatic int alen(int m); return m ? 5 : 4;  endfunction

  function automatic void build_h(int n, int r);
    int t[64];
    for (int i = 0; i < 64; i++) h[i] = 0;
    h[0] = 1;
    hlen = 1;
    for (int s = 0; s < n; s++) begin
      for (int i = 0; i < 64; i++) t[i] = 0;
      for (int i = 0; i < hlen; i++)
        for (int k = 0; k < r; k++) t[i+k] += h[i];
      hlen += r - 1;
      h = t;
    end
  endfunction

  function automatic int expect_group(int g);
    int n = ord(cur_mode);
    int r = rate(cur_mode);
    int l = alen(cur_mode);
    longint s = 0;
    for (int m = n + 1 + g*l; m <= n + (g+1)*l; m++)
      for (int j = 0; j < hlen; j++) begin
        int idx = m*r - 1 - j;
        if (idx >= 0 && idx < xs.size()) s += longint'(h[j]) * xs[idx];
      end
    return int'((s + 2) >>> 2);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge.
  task automatic step(bit v, int code);
    int s0, d, g, e;
    bit exp_pulse;
    in_valid = v;
    in_code  = code[IN_W-1:0];
    @(posedge clk);
    if (v) begin xs.push_back(code); n_acc++; end
    @(negedge clk);
    s0 = (ord(cur_mode) + alen(cur_mode)) * rate(cur_mode);
    d  = alen(cur_mode) * rate(cur_mode);
    exp_pulse = prev_acc && prev_n >= s0 && ((prev_n - s0) % d) == 0;
    if (out_valid || exp_pulse) begin
      chk(out_valid == exp_pulse, (prev_n == s0) ? "R5" : "R4",
          "out_valid pulse position", int'(out_valid), int'(exp_pulse));
      if (out_valid && exp_pulse) begin
        g = (prev_n - s0) / d;
        e = expect_group(g);
        chk($signed(out_data) == e, cur_mode ? "R3" : "R2",
            "output word", int'($signed(out_data)), e);
        last_out = int'($signed(out_data));
        pulses++;
      end
      held = out_data;
    end else begin
      if (out_data != held)
        chk(1'b0, "R9", "out_data held without pulse",
            int'($signed(out_data)), int'($signed(held)));
    end
    prev_acc = v;
    prev_n   = n_acc;
  endtask

  task automatic model_restart(int m);
    xs.delete();
    n_acc = 0; prev_n = 0; prev_acc = 0; held = '0; cur_mode = m;
    build_h(ord(m), rate(m));
  endtask

  task automatic sync_clear(bit m);
    mode_sel = m; srst = 1'b1; in_valid = 1'b1; in_code = '1;
    @(posedge clk);
    @(negedge clk);
    srst = 1'b0;
    chk(!out_valid && out_data == '0, "R8", "outputs after clear",
        int'(out_data), 0);
    model_restart(m);
  endtask

  task automatic rnd_run(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      int c = int'($urandom_range(0, 15)) - 8;
      bit v = gaps ? (($urandom_range(0, 3)) != 0) : 1'b1;
      step(v, c);
    end
  endtask

  task automatic const_run(int n, int c);
    for (int i = 0; i < n; i++) step(1'b1, c);
  endtask

  initial begin
    int p0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; srst = 1'b0; mode_sel = 1'b0; in_valid = 1'b0; in_code = '0;
    pulses = 0; last_out = 0;
    repeat (3) @(negedge clk);
    chk(!out_valid && out_data == '0, "R1", "outputs in reset", int'(out_data), 0);
    rst_n = 1'b1;
    // First edge after release is a clearing cycle: the sample offered is dropped (R8).
    in_valid = 1'b1; in_code = 4'd7;
    @(posedge clk);
    @(negedge clk);
    chk(!out_valid && out_data == '0, "R8", "outputs after boot clear", int'(out_data), 0);
    model_restart(0);

    // Mode 0, random with gaps; mode_sel flips midway with no clear (R7).
    rnd_run(300, 1'b1);
    mode_sel = 1'b1;
    rnd_run(400, 1'b1);
    chk(pulses >= 5, "R7", "mode 0 outputs produced", pulses, 5);

    // Idle stretch with changing codes: nothing is accepted (R6).
    p0 = pulses;
    for (int i = 0; i < 150; i++) step(1'b0, int'($urandom_range(0, 15)) - 8);
    chk(pulses == p0, "R6", "no pulse while idle", pulses, p0);
    rnd_run(200, 1'b0);
    chk(pulses > p0, "R6", "stream resumes after idle", pulses, p0 + 1);

    // Mode 0 full scale.
    sync_clear(1'b0);
    const_run(180, -8);
    chk(last_out == -32768, "R10", "mode 0 negative full scale", last_out, -32768);
    sync_clear(1'b0);
    const_run(180, 7);
    chk(last_out == 28672, "R10", "mode 0 positive full scale", last_out, 28672);

    // Clear into mode 1 (R7 honoured), continuous random; flip mode_sel mid-run.
    sync_clear(1'b1);
    mode_sel = 1'b1;
    rnd_run(120, 1'b0);
    mode_sel = 1'b0;
    p0 = pulses;
    rnd_run(200, 1'b0);
    chk(pulses - p0 == 8, "R7", "mode 1 cadence kept after mode_sel change", pulses - p0, 8);

    // Clear part-way through a group and restart warm-up (R8, R5).
    rnd_run(13, 1'b0);
    sync_clear(1'b1);
    rnd_run(300, 1'b1);

    // Mode 1 full scale.
    sync_clear(1'b1);
    const_run(75, -8);
    chk(last_out == -6250, "R10", "mode 1 negative full scale", last_out, -6250);
    sync_clear(1'b1);
    const_run(75, 7);
    chk(last_out == 5469, "R10", "mode 1 positive full scale", last_out, 5469);

    // Back to mode 0 through a clear.
    sync_clear(1'b0);
    rnd_run(250, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule